// File: doc/BRIEF.md
# Time-Multiplexed Binary Neuron Layer

This block evaluates one layer of eight binary neurons on an 8-bit binary feature vector. Each neuron holds an 8-bit weight row and a signed bias. A feature bit counts as a match when it equals the corresponding weight bit, which is an XNOR test. The matches are summed by a balanced adder tree. The neuron fires when the match count plus its bias is zero or more.

Only one XNOR row and one adder tree exist in the block. A sequencer passes the neurons through this shared datapath one per clock, so a pass takes eight compute cycles. At the end of the pass, the full classification vector is published together with a one-cycle done pulse.

Weights and biases are loaded through a write port while the block is idle. After loading, the block serves any number of passes on fresh feature vectors without reloading. A pass starts with a start pulse, and busy stays high while the pass runs.

Top module: `bnn_layer`

## Requirements
- R1: A synchronous active-high reset clears busy, done, class_out, every weight row and every bias. After reset, a pass on any feature vector therefore returns 8'hFF, because each neuron's count is at least 0 and its bias is 0.
- R2: A feature bit matches when it equals the weight bit (XNOR). A weight bit of 0 therefore matches a feature bit of 0.
- R3: Neuron k outputs 1 exactly when (match count + bias k) >= 0, evaluated without overflow over the whole range, from 8 + 15 down to 0 + (-16).
- R4: A bias is 5-bit two's complement with range -16..+15. For example, 5'h10 is -16, 5'h18 is -8 and 5'h0F is +15.
- R5: The result of neuron k, which is written at index k, appears at class_out bit k.
- R6: feat_in is captured in the cycle where start is accepted. Changes to feat_in during a pass do not affect that pass.
- R7: When start is sampled high with busy low, busy is high for the next 8 cycles. done is high for exactly one cycle, the cycle after the last of those 8, and in that same cycle busy is low again.
- R8: class_out changes only in the cycle where done is high, and otherwise holds its last value.
- R9: A write (wr_en with wr_idx, wr_weight, wr_bias) while busy is high is ignored. A write while idle replaces the row and bias of neuron wr_idx.
- R10: A start pulse while busy is high is ignored and does not restart or extend the pass.
- R11: Weights and biases persist across any number of passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass when idle |
| feat_in | input | 8 | Binary feature vector |
| wr_en | input | 1 | Parameter write strobe |
| wr_idx | input | 3 | Neuron index for the write |
| wr_weight | input | 8 | Weight row to store |
| wr_bias | input | 5 | Two's-complement bias to store |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse when class_out is updated |
| class_out | output | 8 | Classification vector, bit k from neuron k |

## Verification
The bench builds the block with its default parameters: eight neurons, eight feature bits and a 5-bit bias. With these values the bias extremes -16 and +15 are reachable against the count extremes 0 and 8, which exercises both edges of the firing test, including a sum of exactly zero. Per-neuron weight patterns (all ones, all zeros, half, alternating) are chosen so that feature vectors of all ones and all zeros give distinct known vectors. Writes, start pulses and feature changes are also injected in the middle of a pass.

// File: rtl/bnn_pkg.sv
package bnn_pkg;
  localparam int DEF_NEURONS = 8;
  localparam int DEF_FEATS   = 8;
  localparam int DEF_BIAS_W  = 5;
endpackage

// File: rtl/bnn_popcount.sv
module bnn_popcount #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits_i,
  output logic [CW-1:0] count_o
);
  // heap-ordered balanced tree: node 0 is the root, leaves sit at N-1 .. 2N-2
  logic [CW-1:0] node [0:2*N-2];

  for (genvar l = 0; l < N; l++) begin : g_leaf
    assign node[N-1+l] = CW'(bits_i[l]);
  end
  for (genvar i = 0; i < N - 1; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign count_o = node[0];
endmodule

// File: rtl/bnn_param_store.sv
module bnn_param_store #(
  parameter int NEU    = 8,
  parameter int FEAT   = 8,
  parameter int BIAS_W = 5,
  parameter int IDX_W  = $clog2(NEU)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [FEAT-1:0]   wr_weight,
  input  logic [BIAS_W-1:0] wr_bias,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [FEAT-1:0]   rd_weight,
  output logic [BIAS_W-1:0] rd_bias
);
  logic [NEU-1:0][FEAT-1:0]   w_q;
  logic [NEU-1:0][BIAS_W-1:0] b_q;
  logic                       wr_accept;

  assign wr_accept = wr_en && !busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q <= '0;
      b_q <= '0;
    end else if (wr_accept) begin
      w_q[wr_idx] <= wr_weight;
      b_q[wr_idx] <= wr_bias;
    end
  end

  assign rd_weight = w_q[rd_idx];
  assign rd_bias   = b_q[rd_idx];

  // R9: nothing is stored while a pass runs
  a_r9_no_write_busy: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> ($stable(w_q) && $stable(b_q)));
endmodule

// File: rtl/bnn_sequencer.sv
module bnn_sequencer #(
  parameter int NEU   = 8,
  parameter int IDX_W = $clog2(NEU)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             last,
  output logic             start_acc,
  output logic             done
);
  assign start_acc = start && !busy;
  assign last      = busy && (idx == IDX_W'(NEU - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (start_acc) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end
  end

  a_r7_start_busy: assert property (@(posedge clk) disable iff (rst)
    start_acc |=> (busy && idx == '0));
  a_r7_last_done: assert property (@(posedge clk) disable iff (rst)
    last |=> (done && !busy));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> (busy && idx == $past(idx) + 1'b1));
endmodule

// File: rtl/bnn_layer.sv
module bnn_layer #(
  parameter int NEU    = bnn_pkg::DEF_NEURONS,
  parameter int FEAT   = bnn_pkg::DEF_FEATS,
  parameter int BIAS_W = bnn_pkg::DEF_BIAS_W,
  parameter int IDX_W  = $clog2(NEU)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FEAT-1:0]   feat_in,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [FEAT-1:0]   wr_weight,
  input  logic [BIAS_W-1:0] wr_bias,
  output logic              busy,
  output logic              done,
  output logic [NEU-1:0]    class_out
);
  localparam int CW    = $clog2(FEAT + 1);
  localparam int SUM_W = ((CW > BIAS_W) ? CW : BIAS_W) + 1;

  // count is unsigned, bias signed; both widened to SUM_W so no extreme overflows
  function automatic logic fires(input logic [CW-1:0] cnt, input logic [BIAS_W-1:0] bias);
    logic [SUM_W-1:0] s;
    s = {{(SUM_W-CW){1'b0}}, cnt} + {{(SUM_W-BIAS_W){bias[BIAS_W-1]}}, bias};
    return !s[SUM_W-1];
  endfunction

  logic [IDX_W-1:0]  idx;
  logic              last;
  logic              start_acc;
  logic [FEAT-1:0]   feat_q;
  logic [FEAT-1:0]   row_w;
  logic [BIAS_W-1:0] row_b;
  logic [FEAT-1:0]   match;
  logic [CW-1:0]     match_cnt;
  logic              neuron_fire;
  logic [NEU-1:0]    work_q;
  logic [NEU-1:0]    work_nx;

  bnn_sequencer #(.NEU(NEU), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .idx(idx),
    .last(last), .start_acc(start_acc), .done(done)
  );

  bnn_param_store #(.NEU(NEU), .FEAT(FEAT), .BIAS_W(BIAS_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .busy_i(busy), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_weight(wr_weight), .wr_bias(wr_bias), .rd_idx(idx),
    .rd_weight(row_w), .rd_bias(row_b)
  );

  assign match = ~(row_w ^ feat_q);

  bnn_popcount #(.N(FEAT), .CW(CW)) u_pop (
    .bits_i(match), .count_o(match_cnt)
  );

  assign neuron_fire = fires(match_cnt, row_b);

  always_comb begin
    work_nx      = work_q;
    work_nx[idx] = neuron_fire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      feat_q    <= '0;
      work_q    <= '0;
      class_out <= '0;
    end else begin
      if (start_acc) feat_q <= feat_in;
      if (busy) work_q <= work_nx;
      if (last) class_out <= work_nx;
    end
  end

  a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (match_cnt <= CW'(FEAT)));
  a_r6_feat_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(feat_q));
  a_r8_hold_out: assert property (@(posedge clk) disable iff (rst)
    !$stable(class_out) |-> done);
endmodule

// File: tb/bnn_layer_bench.sv
module bnn_layer_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [7:0] feat_in;
  logic       wr_en;
  logic [2:0] wr_idx;
  logic [7:0] wr_weight;
  logic [4:0] wr_bias;
  logic       busy, done;
  logic [7:0] class_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bnn_layer u_bnn_layer (
    .clk(clk), .rst(rst), .start(start), .feat_in(feat_in), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_weight(wr_weight), .wr_bias(wr_bias),
    .busy(busy), .done(done), .class_out(class_out)
  );

  // behavioural reference
  int         m_w [8];
  int         m_b [8];
  int         m_k;
  bit         m_busy, m_done;
  logic [7:0] m_out, m_work, m_feat;

  function automatic bit ref_fire(int w, logic [7:0] f, int b);
    int hits = 0;
    for (int i = 0; i < 8; i++) if (w[i] == f[i]) hits++;
    return (hits + b) >= 0;
  endfunction

  always @(posedge clk) begin
    bit was_busy;
    was_busy = m_busy;
    if (rst) begin
      for (int i = 0; i < 8; i++) begin m_w[i] = 0; m_b[i] = 0; end
      m_busy = 0; m_done = 0; m_out = 0; m_work = 0; m_feat = 0; m_k = 0;
    end else begin
      m_done = 0;
      if (was_busy) begin
        m_work[m_k] = ref_fire(m_w[m_k], m_feat, m_b[m_k]);
        if (m_k == 7) begin m_out = m_work; m_done = 1; m_busy = 0; end
        else m_k++;
      end else if (start) begin
        m_feat = feat_in; m_busy = 1; m_k = 0;
      end
      if (wr_en && !was_busy) begin
        m_w[wr_idx] = wr_weight;
        m_b[wr_idx] = (wr_bias >= 16) ? int'(wr_bias) - 32 : int'(wr_bias);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst && !finished) begin
      check("R7 busy", busy, m_busy);
      check("R7 done", done, m_done);
      check("R8 class_out", class_out, m_out);
    end
    if (cycles > 20000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic write_row(int i, logic [7:0] w, logic [4:0] b);
    wr_en = 1; wr_idx = 3'(i); wr_weight = w; wr_bias = b;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run_pass(logic [7:0] f);
    feat_in = f; start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    rst = 1; start = 0; feat_in = 0; wr_en = 0; wr_idx = 0; wr_weight = 0; wr_bias = 0;
    repeat (3) @(negedge clk);
    check("R1 busy reset", busy, 0);
    check("R1 done reset", done, 0);
    check("R1 class_out reset", class_out, 0);
    rst = 0;
    @(negedge clk);
    run_pass(8'h5A);
    check("R1 zero params fire all", class_out, 8'hFF);

    write_row(0, 8'hFF, 5'h18); // -8
    write_row(1, 8'hFF, 5'h17); // -9
    write_row(2, 8'h00, 5'h10); // -16
    write_row(3, 8'hF0, 5'h1C); // -4
    write_row(4, 8'h0F, 5'h1B); // -5
    write_row(5, 8'hAA, 5'h0F); // +15
    write_row(6, 8'h00, 5'h00); // 0
    write_row(7, 8'hFF, 5'h10); // -16
    run_pass(8'hFF);
    check("R3 R4 R5 all-ones features", class_out, 8'h69);
    run_pass(8'h00);
    check("R2 R3 R4 all-zero features", class_out, 8'h68);

    // R6 R9 R10: disturb a pass in flight
    feat_in = 8'h00; start = 1;
    @(negedge clk);
    start = 0; feat_in = 8'hFF;
    @(negedge clk);
    start = 1;                   // R10 ignored
    wr_en = 1; wr_idx = 3'd6; wr_weight = 8'hFF; wr_bias = 5'h10; // R9 ignored
    @(negedge clk);
    start = 0; wr_en = 0;
    while (!done) @(negedge clk);
    check("R6 R9 R10 disturbed pass", class_out, 8'h68);
    @(negedge clk);
    check("R7 done one cycle", done, 0);

    repeat (5) @(negedge clk);
    check("R8 held while idle", class_out, 8'h68);
    run_pass(8'h00);
    check("R9 R11 params kept", class_out, 8'h68);
    run_pass(8'h3C);
    check("R11 repeated pass", class_out, m_out);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule